// File: doc/BRIEF.md
# MDIO PHY Bring-up Sequencer and Link Monitor

This block takes an Ethernet PHY from power-on to a monitored link using only the two-wire management interface. After reset it reads the two identifier registers and compares their contents against a PHY profile held in parameters. It then soft-resets the PHY and waits for the reset bit to clear. Next it writes the advertisement word and restarts autonegotiation. From then on it polls a status register at a fixed interval.

Each poll reads the status register twice and decodes link, speed and duplex from the second value. The second read is used because the link bit latches low on loss of link. The register address and the three bit positions come from the profile, so one sequencer can serve PHYs from different vendors. The block contains its own management master. That master generates the clock, builds each frame, captures read data and controls the output enable of the data line.

Top module: `mdio_phy_mon`

## Requirements
- R1: The first two transactions after reset read register 2, then register 3. Register 2 holds the OUI bits [21:6]. Register 3 holds OUI [5:0] in [15:10], the 6-bit model in [9:4] and the 4-bit revision in [3:0]. `id_match` is 1 only when all three fields equal the profile.
- R2: The first write puts 0x8000 into register 0. The block then reads register 0 repeatedly, and issues no further write until a read returns bit 15 = 0.
- R3: If bit 15 of register 0 still reads 1 after `RST_POLLS` reads, `error` rises. After that there are no more frames, and `busy` is 0.
- R4: After the reset clears, the block writes `ADV_VALUE` (default 0x01E1) to register 4. It then writes 0x1200 to register 0, and only then starts polling status.
- R5: If `ADV_VALUE[4:0]` (the selector) is zero, `error` is 1 from reset and no frame is ever driven.
- R6: Every frame is sent MSB first and has 32 ones, then 01, then the opcode (01 write, 10 read), the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround (10 on writes) and 16 data bits. On reads, `mdio_oe` is 0 for the turnaround and the data bits.
- R7: Within a frame, `mdc` high and low phases each last `MDC_HALF` system clocks. `mdio_o` changes only on a falling `mdc`. Read data is sampled on the rising `mdc`. `mdc` is 0 between frames.
- R8: Each status poll is two reads of `STAT_REG`. `link_up`, `speed_100` and `full_duplex` take bits `LINK_BIT`, `SPEED_BIT` and `DUPLEX_BIT` of the second read. A link bit that was low only on the first read leaves `link_up` at 1.
- R9: `busy` is 1 during reset and from reset until the first status poll completes. It is also 1 during every frame, and 0 otherwise, including in the error state.
- R10: Between the end of one status poll and the start of the next, `busy` is 0 for exactly `POLL_GAP` clocks.
- R11: Once `error` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data driven onto the line when enabled |
| mdio_oe | output | 1 | Output enable for the data line |
| link_up | output | 1 | Link bit from the latest status poll |
| speed_100 | output | 1 | Speed bit from the latest status poll |
| full_duplex | output | 1 | Duplex bit from the latest status poll |
| id_match | output | 1 | PHY identifier equals the profile |
| busy | output | 1 | Bring-up in progress or frame active |
| error | output | 1 | Reset timeout or bad advertisement selector |

## Verification
The bench builds the main instance with `MDC_HALF` = 2, `POLL_GAP` = 40 and `RST_POLLS` = 4. With these values a full frame takes 256 clocks, so bring-up, many status polls and a reset timeout all fit into a short run. A behavioural PHY on the line can be told to hold its reset bit for any number of reads, to drop its link only in the latched copy, or to report a different model. That covers the clear-after-polls path, the timeout path, the latch-low rule and an identity mismatch. A second instance built with selector bits of zero shows the configuration error and stays off the line.

// File: rtl/mdio_mon_pkg.sv
// Package: shared constants and sequencer state type for the PHY monitor.
// Assumes clause-22 style management frames of 64 bits.
package mdio_mon_pkg;

    localparam logic [1:0]  OP_WRITE      = 2'b01;
    localparam logic [1:0]  OP_READ       = 2'b10;
    localparam int          TA_FIRST_BIT  = 46;
    localparam int          DATA_FIRST_BIT = 48;
    localparam int          LAST_BIT      = 63;

    localparam logic [4:0]  ADDR_CTRL     = 5'd0;
    localparam logic [4:0]  ADDR_ID_HI    = 5'd2;
    localparam logic [4:0]  ADDR_ID_LO    = 5'd3;
    localparam logic [4:0]  ADDR_ADV      = 5'd4;

    localparam logic [15:0] CTRL_SOFT_RST = 16'h8000;
    localparam logic [15:0] CTRL_AN_START = 16'h1200;

    typedef enum logic [3:0] {
        S_ID_HI,
        S_ID_LO,
        S_RST_WR,
        S_RST_POLL,
        S_ADV_WR,
        S_AN_WR,
        S_STAT1,
        S_STAT2,
        S_WAIT,
        S_ERR
    } seq_state_t;

endpackage

// File: rtl/mdio_frame_master.sv
// Module: management frame master.
// Builds one 64-bit frame per start request, generates mdc only while a
// frame is active, changes output data on mdc falling and samples read
// data on mdc rising. Assumes start_i is only raised while idle.
module mdio_frame_master
    import mdio_mon_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        write_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdata_i,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    localparam int CW = $clog2(MDC_HALF) + 1;

    logic          active;
    logic          is_wr;
    logic [62:0]   frame;
    logic [5:0]    bit_idx;
    logic [CW-1:0] div_cnt;
    logic [63:0]   next_frame;

    // Assemble the outgoing frame from the request fields.
    always_comb begin
        next_frame = {32'hFFFF_FFFF, 2'b01, (write_i ? OP_WRITE : OP_READ),
                      phy_i, reg_i, 2'b10, (write_i ? wdata_i : 16'h0000)};
    end

    // Clock divider, bit shifter and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            is_wr     <= 1'b0;
            frame     <= '0;
            bit_idx   <= '0;
            div_cnt   <= '0;
            mdc_o     <= 1'b0;
            mdio_o    <= 1'b1;
            mdio_oe_o <= 1'b0;
            rdata_o   <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                mdc_o   <= 1'b0;
                div_cnt <= '0;
                if (start_i) begin
                    active    <= 1'b1;
                    is_wr     <= write_i;
                    frame     <= next_frame[62:0];
                    bit_idx   <= '0;
                    mdio_o    <= next_frame[63];
                    mdio_oe_o <= 1'b1;
                end
            end else if (div_cnt == CW'(MDC_HALF - 1)) begin
                div_cnt <= '0;
                mdc_o   <= ~mdc_o;
                if (!mdc_o) begin
                    if (!is_wr && bit_idx >= 6'(DATA_FIRST_BIT))
                        rdata_o <= {rdata_o[14:0], mdio_i};
                end else if (bit_idx == 6'(LAST_BIT)) begin
                    active    <= 1'b0;
                    mdio_oe_o <= 1'b0;
                    done_o    <= 1'b1;
                end else begin
                    bit_idx   <= bit_idx + 6'd1;
                    mdio_o    <= frame[6'd62 - bit_idx];
                    mdio_oe_o <= is_wr || (bit_idx < 6'(TA_FIRST_BIT - 1));
                end
            end else begin
                div_cnt <= div_cnt + CW'(1);
            end
        end
    end

    // R6: the sequencer never requests a frame while one is running
    p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active);

    // R7: mdc stays low outside frames
    p_mdc_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdc_o);

    // R7: driven data only moves on a falling mdc
    p_data_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o && $past(mdio_oe_o) && !$stable(mdio_o)) |-> $fell(mdc_o));

endmodule

// File: rtl/phy_bringup_seq.sv
// Module: bring-up and status poll sequencer.
// Walks identity read, soft reset, advertisement and autonegotiation
// restart, then polls status forever. Hands one request at a time to the
// frame master and waits for its done pulse. Assumes rdata_i is valid with done_i.
module phy_bringup_seq
    import mdio_mon_pkg::*;
#(
    parameter logic [21:0] EXP_OUI    = 22'h080017,
    parameter logic [5:0]  EXP_MODEL  = 6'h09,
    parameter logic [3:0]  EXP_REV    = 4'h0,
    parameter logic [4:0]  STAT_REG   = 5'd1,
    parameter int          SPEED_BIT  = 14,
    parameter int          DUPLEX_BIT = 13,
    parameter int          LINK_BIT   = 2,
    parameter logic [15:0] ADV_VALUE  = 16'h01E1,
    parameter int          RST_POLLS  = 8,
    parameter int          POLL_GAP   = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        start_o,
    output logic        write_o,
    output logic [4:0]  reg_o,
    output logic [15:0] wdata_o,
    input  logic        done_i,
    input  logic [15:0] rdata_i,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        id_match,
    output logic        busy,
    output logic        error
);
    localparam logic ADV_OK = (ADV_VALUE[4:0] != 5'd0);
    localparam int   PW     = $clog2(RST_POLLS) + 1;
    localparam int   GW     = $clog2(POLL_GAP) + 1;

    seq_state_t    state;
    logic          inflight;
    logic          req_valid;
    logic [15:0]   id_hi;
    logic [PW-1:0] poll_cnt;
    logic [GW-1:0] gap_cnt;

    // Map each state to the frame it needs.
    always_comb begin
        req_valid = 1'b1;
        write_o   = 1'b0;
        reg_o     = ADDR_CTRL;
        wdata_o   = 16'h0000;
        case (state)
            S_ID_HI:    reg_o = ADDR_ID_HI;
            S_ID_LO:    reg_o = ADDR_ID_LO;
            S_RST_WR:   begin write_o = 1'b1; wdata_o = CTRL_SOFT_RST; end
            S_RST_POLL: reg_o = ADDR_CTRL;
            S_ADV_WR:   begin write_o = 1'b1; reg_o = ADDR_ADV; wdata_o = ADV_VALUE; end
            S_AN_WR:    begin write_o = 1'b1; wdata_o = CTRL_AN_START; end
            S_STAT1,
            S_STAT2:    reg_o = STAT_REG;
            default:    req_valid = 1'b0;
        endcase
    end

    // Issue a request once per state visit.
    assign start_o = req_valid && !inflight;
    assign busy    = (state != S_WAIT) && (state != S_ERR);
    assign error   = (state == S_ERR);

    // Step the sequence on each completed frame and time the poll gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ADV_OK ? S_ID_HI : S_ERR;
            inflight    <= 1'b0;
            id_hi       <= '0;
            id_match    <= 1'b0;
            poll_cnt    <= '0;
            gap_cnt     <= '0;
            link_up     <= 1'b0;
            speed_100   <= 1'b0;
            full_duplex <= 1'b0;
        end else begin
            if (start_o) inflight <= 1'b1;
            if (inflight && done_i) begin
                inflight <= 1'b0;
                case (state)
                    S_ID_HI: begin
                        id_hi <= rdata_i;
                        state <= S_ID_LO;
                    end
                    S_ID_LO: begin
                        id_match <= (id_hi == EXP_OUI[21:6]) && (rdata_i[15:10] == EXP_OUI[5:0])
                                 && (rdata_i[9:4] == EXP_MODEL) && (rdata_i[3:0] == EXP_REV);
                        state    <= S_RST_WR;
                    end
                    S_RST_WR: begin
                        poll_cnt <= '0;
                        state    <= S_RST_POLL;
                    end
                    S_RST_POLL: begin
                        if (!rdata_i[15])                             state <= S_ADV_WR;
                        else if (poll_cnt == PW'(RST_POLLS - 1))      state <= S_ERR;
                        else                                          poll_cnt <= poll_cnt + PW'(1);
                    end
                    S_ADV_WR: state <= S_AN_WR;
                    S_AN_WR:  state <= S_STAT1;
                    S_STAT1:  state <= S_STAT2;
                    S_STAT2: begin
                        link_up     <= rdata_i[LINK_BIT];
                        speed_100   <= rdata_i[SPEED_BIT];
                        full_duplex <= rdata_i[DUPLEX_BIT];
                        gap_cnt     <= '0;
                        state       <= S_WAIT;
                    end
                    default: ;
                endcase
            end
            if (state == S_WAIT) begin
                if (gap_cnt == GW'(POLL_GAP - 1)) begin
                    gap_cnt <= '0;
                    state   <= S_STAT1;
                end else begin
                    gap_cnt <= gap_cnt + GW'(1);
                end
            end
        end
    end

    // R11: the error state holds until reset
    p_error_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R1: identity result only changes while bring-up is running
    p_id_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(id_match));

    // R8: decoded status holds between polls
    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && $past(state == S_WAIT)) |-> ($stable(link_up) && $stable(speed_100) && $stable(full_duplex)));

    // R3: no request is raised once in error
    p_no_req_in_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !start_o);

endmodule

// File: rtl/mdio_phy_mon.sv
// Module: top of the PHY bring-up and link monitor.
// Joins the sequencer to the frame master; the data line is left to the
// pad as output, enable and input. Assumes a single PHY at PHY_ADDR.
module mdio_phy_mon #(
    parameter logic [4:0]  PHY_ADDR   = 5'd1,
    parameter logic [21:0] EXP_OUI    = 22'h080017,
    parameter logic [5:0]  EXP_MODEL  = 6'h09,
    parameter logic [3:0]  EXP_REV    = 4'h0,
    parameter logic [4:0]  STAT_REG   = 5'd1,
    parameter int          SPEED_BIT  = 14,
    parameter int          DUPLEX_BIT = 13,
    parameter int          LINK_BIT   = 2,
    parameter logic [15:0] ADV_VALUE  = 16'h01E1,
    parameter int          MDC_HALF   = 4,
    parameter int          RST_POLLS  = 8,
    parameter int          POLL_GAP   = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    input  logic mdio_i,
    output logic mdio_o,
    output logic mdio_oe,
    output logic link_up,
    output logic speed_100,
    output logic full_duplex,
    output logic id_match,
    output logic busy,
    output logic error
);
    logic        req_start;
    logic        req_write;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        xfer_done;
    logic [15:0] xfer_rdata;

    phy_bringup_seq #(
        .EXP_OUI(EXP_OUI), .EXP_MODEL(EXP_MODEL), .EXP_REV(EXP_REV),
        .STAT_REG(STAT_REG), .SPEED_BIT(SPEED_BIT), .DUPLEX_BIT(DUPLEX_BIT),
        .LINK_BIT(LINK_BIT), .ADV_VALUE(ADV_VALUE), .RST_POLLS(RST_POLLS),
        .POLL_GAP(POLL_GAP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_o(req_start), .write_o(req_write), .reg_o(req_reg), .wdata_o(req_wdata),
        .done_i(xfer_done), .rdata_i(xfer_rdata),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .id_match(id_match), .busy(busy), .error(error)
    );

    mdio_frame_master #(
        .MDC_HALF(MDC_HALF)
    ) u_master (
        .clk(clk), .rst_n(rst_n),
        .start_i(req_start), .write_i(req_write), .phy_i(PHY_ADDR),
        .reg_i(req_reg), .wdata_i(req_wdata),
        .done_o(xfer_done), .rdata_o(xfer_rdata),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    // R9: the line is only driven while busy
    p_drive_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R3: in error the bus is quiet
    p_quiet_in_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!mdio_oe && !mdc));

endmodule

// File: tb/mdio_phy_mon_test.sv
module mdio_phy_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF   = 2;
    localparam int GAP    = 40;
    localparam int RPOLLS = 4;
    localparam logic [21:0] OUI = 22'h080017;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc, mdio_o, mdio_oe, link_up, speed_100, full_duplex, id_match, busy, error;
    logic cfg_mdc, cfg_o, cfg_oe, cfg_link, cfg_spd, cfg_dup, cfg_id, cfg_busy, cfg_err;
    logic phy_oe = 1'b0, phy_o = 1'b1;
    logic bus;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_phy_mon #(.MDC_HALF(HALF), .RST_POLLS(RPOLLS), .POLL_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .id_match(id_match), .busy(busy), .error(error));

    mdio_phy_mon #(.MDC_HALF(HALF), .RST_POLLS(RPOLLS), .POLL_GAP(GAP), .ADV_VALUE(16'h01E0)) uut_cfg (
        .clk(clk), .rst_n(rst_n), .mdc(cfg_mdc), .mdio_i(1'b1), .mdio_o(cfg_o), .mdio_oe(cfg_oe),
        .link_up(cfg_link), .speed_100(cfg_spd), .full_duplex(cfg_dup),
        .id_match(cfg_id), .busy(cfg_busy), .error(cfg_err));

    int total = 0, bad = 0;
    logic finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural PHY ----------------
    int rst_cfg = 2;                 // reads that still show bit 15 set
    logic [15:0] id2 = OUI[21:6];
    logic [15:0] id3 = {OUI[5:0], 6'h09, 4'h0};
    logic ph_spd = 1'b1, ph_dup = 1'b1, link_now = 1'b1;
    int drop_cnt = 0;

    int pst = 0, ones = 0, n = 0, k = 0, rst_left = 0, seen_drop = 0;
    logic [11:0] hdr;
    logic [17:0] wsh;
    logic [15:0] rdval;
    logic link_lat = 1'b1;
    int r0_reads = 0, stat_reads = 0, wr_n = 0, rd_n = 0, frame_bad = 0;
    logic clear_seen = 1'b0, adv_after_clear = 1'b0;
    logic [4:0]  wr_reg [0:63];
    logic [15:0] wr_dat [0:63];
    logic [4:0]  rd_reg [0:255];
    logic exp_link = 1'b0, exp_spd = 1'b0, exp_dup = 1'b0, first_link = 1'b0;

    always @(mdc) begin
        if (seen_drop != drop_cnt) begin seen_drop = drop_cnt; link_lat = 1'b0; end
        if (mdc) begin
            case (pst)
                0: if (bus) ones++; else begin if (ones >= 32) pst = 1; ones = 0; end
                1: if (bus) begin pst = 2; n = 0; hdr = '0; end else begin pst = 0; ones = 0; end
                2: begin
                    hdr = {hdr[10:0], bus}; n++;
                    if (n == 12) begin
                        if (hdr[9:5] != 5'd1) frame_bad++;
                        if (hdr[11:10] == 2'b10) begin
                            pst = 3; k = 0;
                            if (rd_n < 256) rd_reg[rd_n] = hdr[4:0];
                            rd_n++;
                        end else if (hdr[11:10] == 2'b01) begin
                            pst = 4; n = 0; wsh = '0;
                        end else begin
                            frame_bad++; pst = 0; ones = 0;
                        end
                    end
                end
                4: begin
                    wsh = {wsh[16:0], bus}; n++;
                    if (n == 18) begin
                        if (wsh[17:16] != 2'b10) frame_bad++;
                        if (wr_n < 64) begin wr_reg[wr_n] = hdr[4:0]; wr_dat[wr_n] = wsh[15:0]; end
                        wr_n++;
                        if (hdr[4:0] == 5'd0 && wsh[15]) begin rst_left = rst_cfg; clear_seen = 1'b0; end
                        if (hdr[4:0] == 5'd4) adv_after_clear = clear_seen;
                        pst = 0; ones = 0;
                    end
                end
                default: ;
            endcase
        end else if (pst == 3) begin
            k++;
            if (k == 1) phy_oe = 1'b0;
            else if (k == 2) begin
                phy_oe = 1'b1; phy_o = 1'b0;
                case (hdr[4:0])
                    5'd0: begin
                        r0_reads++;
                        if (rst_left > 0) begin rdval = 16'h8000; rst_left--; end
                        else begin rdval = 16'h1000; clear_seen = 1'b1; end
                    end
                    5'd2: rdval = id2;
                    5'd3: rdval = id3;
                    5'd1: begin
                        rdval = 16'h1809;
                        rdval[14] = ph_spd; rdval[13] = ph_dup; rdval[2] = link_now & link_lat;
                        link_lat = link_now;
                        stat_reads++;
                        if (stat_reads % 2 == 0) begin
                            exp_link = rdval[2]; exp_spd = rdval[14]; exp_dup = rdval[13];
                        end else first_link = rdval[2];
                    end
                    default: rdval = 16'hFFFF;
                endcase
            end else if (k <= 18) phy_o = rdval[18-k];
            else begin phy_oe = 1'b0; pst = 0; ones = 0; end
        end
    end

    // ---------------- per-clock reference comparison ----------------
    int low_run = 0, gap_seen = 0, gap_bad = 0, mdc_run = 0, mdc_bad = 0, data_bad = 0, cfg_drive = 0;
    logic p_busy = 1'b1, p_mdc = 1'b0, p_oe = 1'b0, p_o = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            low_run = 0; p_busy = 1'b1;
        end else begin
            if (!busy && !error) begin
                check(link_up == exp_link && speed_100 == exp_spd && full_duplex == exp_dup, "R8",
                      {link_up, speed_100, full_duplex}, {exp_link, exp_spd, exp_dup});
                low_run++;
            end
            if (busy && !p_busy) begin
                gap_seen++;
                if (low_run != GAP) begin
                    gap_bad++;
                    $display("FAIL R10 actual=%0d expected=%0d", low_run, GAP);
                end
            end
            if (busy) low_run = 0;
            if (mdc != p_mdc) begin
                if (p_mdc && mdc_run != HALF) mdc_bad++;
                mdc_run = 1;
            end else mdc_run++;
            if (mdio_oe && !busy) mdc_bad++;
            if (mdio_oe && p_oe && mdio_o != p_o && !(p_mdc && !mdc)) data_bad++;
            if (cfg_oe || cfg_mdc) cfg_drive++;
            p_busy = busy;
        end
        p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic wait_poll();
        for (int i = 0; i < 30000; i++) begin @(negedge clk); if (busy) break; end
        wait_idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    int w0, r0;
    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(busy && !error && !link_up && !id_match && !mdc && !mdio_oe, "R9 reset",
              {busy, error, link_up, id_match, mdc, mdio_oe}, 6'b100000);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(cfg_err && !cfg_busy, "R5 selector zero", {cfg_err, cfg_busy}, 2'b10);
        check(busy, "R9 busy during bring-up", busy, 1);

        wait_idle();
        check(id_match == 1'b1, "R1 id match", id_match, 1);
        check(rd_reg[0] == 5'd2 && rd_reg[1] == 5'd3, "R1 id read order", {rd_reg[0], rd_reg[1]}, {5'd2, 5'd3});
        check(wr_n == 3, "R4 write count", wr_n, 3);
        check(wr_reg[0] == 5'd0 && wr_dat[0] == 16'h8000, "R2 soft reset write", wr_dat[0], 16'h8000);
        check(r0_reads == rst_cfg + 1, "R2 reset polls", r0_reads, rst_cfg + 1);
        check(adv_after_clear, "R2 write waits for clear", adv_after_clear, 1);
        check(wr_reg[1] == 5'd4 && wr_dat[1] == 16'h01E1, "R4 advertisement", wr_dat[1], 16'h01E1);
        check(wr_reg[2] == 5'd0 && wr_dat[2] == 16'h1200, "R4 autoneg restart", wr_dat[2], 16'h1200);
        check(link_up && speed_100 && full_duplex, "R8 first status", {link_up, speed_100, full_duplex}, 3'b111);
        check(!error, "R3 no error on clean bring-up", error, 0);

        ph_spd = 1'b0; ph_dup = 1'b0;
        wait_poll(); wait_poll();
        check(!speed_100 && !full_duplex && link_up, "R8 10M half", {link_up, speed_100, full_duplex}, 3'b100);
        link_now = 1'b0;
        wait_poll(); wait_poll();
        check(!link_up, "R8 link down", link_up, 0);
        link_now = 1'b1;
        wait_poll(); wait_poll();
        check(link_up, "R8 link back", link_up, 1);
        drop_cnt++;   // momentary drop seen only by the latch
        wait_poll();
        check(!first_link && link_up, "R8 latch-low uses second read", {first_link, link_up}, 2'b01);

        // identity mismatch on model
        id3 = {OUI[5:0], 6'h0A, 4'h0};
        do_reset();
        wait_idle();
        check(!id_match, "R1 model mismatch", id_match, 0);
        id3 = {OUI[5:0], 6'h09, 4'h0};

        // reset bit never clears
        rst_cfg = 100;
        w0 = wr_n; r0 = r0_reads;
        do_reset();
        for (int i = 0; i < 30000; i++) begin @(negedge clk); if (error) break; end
        check(error && !busy, "R3 timeout error", {error, busy}, 2'b10);
        check(r0_reads - r0 == RPOLLS, "R3 poll count", r0_reads - r0, RPOLLS);
        check(wr_n - w0 == 1, "R3 no writes after timeout", wr_n - w0, 1);
        repeat (600) @(negedge clk);
        check(error && wr_n - w0 == 1 && r0_reads - r0 == RPOLLS, "R11 error sticky", error, 1);

        check(cfg_drive == 0 && cfg_err, "R5 no frames", cfg_drive, 0);
        check(gap_seen > 0 && gap_bad == 0, "R10 poll gap", gap_bad, 0);
        check(mdc_bad == 0, "R7 mdc phase", mdc_bad, 0);
        check(data_bad == 0, "R7 data on falling edge", data_bad, 0);
        check(frame_bad == 0 && rd_n > 0, "R6 frame format", frame_bad, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule